// File: doc/BRIEF.md
# Multi-mode configuration bitstream streamer

This block is the master-side sequencer that loads configuration data into one or more downstream programmable devices. It reads bytes from a simple memory-read port with one cycle of latency. It presents them on an 8-bit data bus, together with a configuration clock that it generates by dividing the system clock. The targets sample the bus on the rising edge of that clock. The block changes the bus only as the clock falls, so the bus is always settled at the sample point.

Three modes share one datapath. Parallel mode sends a whole byte on every configuration clock. Serial mode sends one bit per clock on lane 0, least significant bit first, and holds the other lanes low. Concurrent mode drives 1, 2, 4 or 8 independent serial lanes. Each lane carries its own stream, and all lanes share the one clock.

After the last byte the block issues a programmable number of extra clocks so that the targets can initialize. It then waits for the shared done line. Two events restart the whole configuration from the first byte: a low level on the shared status line, or a done line that stays low past a timeout.

Top module: `cfg_streamer`

## Requirements
- R1: In parallel mode (mode_sel = 0), the bus carries the byte at memory address i during the i-th configuration clock rising edge, counting from 0. The block reads exactly the addresses 0 to stream_len-1, and reads memory only while busy is high.
- R2: In serial mode (mode_sel = 1, and mode_sel = 3 is treated the same way), beat b carries bit b mod 8 of the byte at address b/8 on data[0]. This sends each byte least significant bit first. data[7:1] stay 0 throughout.
- R3: In concurrent mode (mode_sel = 2), the lane width W comes from lane_cnt. A count of 0 or 1 gives W = 1, 2 gives W = 2, 3 or 4 gives W = 4, and 5 to 8 gives W = 8. On beat b, lane k < W carries bit b mod 8 of the byte at address (b/8)*W + k. Lanes k >= W stay 0.
- R4: The data bus changes only in the cycle in which the configuration clock goes low, or while it is low. It is stable for the whole time the clock is high.
- R5: After the last data beat, the block issues exactly extra_clks further clock periods with data 0. The clock then stays low.
- R6: cfg_done rises only after conf_done_in has been seen high once the stream and the extra clocks are complete. When cfg_done rises, busy falls.
- R7: If nstatus_in is low during a configuration, the clock and data go low within 3 cycles and cfg_err pulses. Once nstatus_in is high again, the whole configuration starts over from address 0.
- R8: If conf_done_in is still low TIMEOUT cycles after the extra clocks, cfg_err pulses and the configuration starts over from address 0.
- R9: The block latches mode_sel and lane_cnt on start. Later changes to these inputs have no effect, and restarts caused by R7 or R8 also use the latched values.
- R10: After reset, dclk, data, busy, cfg_done, cfg_err and mem_rd are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a configuration and latches mode and lane count |
| mode_sel | input | 2 | 0 parallel, 1 serial, 2 concurrent, 3 serial |
| lane_cnt | input | 4 | Number of concurrent chains, 0 to 8 |
| stream_len | input | LW | Bytes per lane (parallel and serial: total bytes), at least 1 |
| extra_clks | input | EW | Clock periods added after the last data beat |
| nstatus_in | input | 1 | Shared status line, low means error |
| conf_done_in | input | 1 | Shared done line, high means all targets are ready |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| dclk | output | 1 | Generated configuration clock |
| data | output | 8 | Configuration data bus |
| busy | output | 1 | A configuration is in progress |
| cfg_done | output | 1 | Targets have entered user mode |
| cfg_err | output | 1 | One-cycle pulse on a fault or timeout restart |

## Verification
The hardest situation to reach is a restart in the middle of a concurrent stream. To reach it, the bench waits until several beats of a three-chain, 4-bit-wide stream have been captured. It then holds the status line low, checks that the bus and the clock are quiet, and releases the line. After that it requires the complete expected stream to appear again from the first beat. The timeout restart is reached by never raising the done line on the first pass. Every run also changes the mode and lane inputs right after start, so that both kinds of restart confirm that the latched values are reused.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    MODE_PAR  = 2'd0,
    MODE_SER  = 2'd1,
    MODE_CONC = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_STREAM,
    ST_FLUSH,
    ST_WAITD,
    ST_HOLD,
    ST_DONE
  } state_e;

  // Round the requested chain count up to a supported lane width.
  function automatic logic [3:0] lane_width(input logic [3:0] cnt);
    if (cnt <= 4'd1)      return 4'd1;
    else if (cnt == 4'd2) return 4'd2;
    else if (cnt <= 4'd4) return 4'd4;
    else                  return 4'd8;
  endfunction

  function automatic mode_e decode_mode(input logic [1:0] m);
    case (m)
      2'd0:    return MODE_PAR;
      2'd2:    return MODE_CONC;
      default: return MODE_SER;
    endcase
  endfunction

  function automatic logic [7:0] lane_mask(input logic [3:0] w);
    logic [8:0] m;
    m = (9'd1 << w) - 9'd1;
    return m[7:0];
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_fetch.sv
module cfg_fetch #(
  parameter int AW = 12,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [LW-1:0]    len,
  input  logic [3:0]       width,
  input  logic             consume,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic [7:0][7:0]  bytes_o,
  output logic             full_o
);
  logic          issuing;
  logic [2:0]    k;
  logic [AW-1:0] addr;
  logic [LW-1:0] grp;
  logic          rd_q;
  logic          last_q;
  logic [2:0]    k_q;
  logic          full;
  logic [7:0]    buf_q [8];
  logic          k_last;

  assign k_last = (k == 3'(width - 4'd1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      issuing <= 1'b0;
      k       <= '0;
      addr    <= '0;
      grp     <= '0;
      rd_q    <= 1'b0;
      last_q  <= 1'b0;
      k_q     <= '0;
      full    <= 1'b0;
    end else begin
      if (consume) full <= 1'b0;
      if (issuing) begin
        addr <= addr + 1'b1;
        k    <= k + 1'b1;
        if (k_last) begin
          issuing <= 1'b0;
          grp     <= grp + 1'b1;
        end
      end else if (!full && !rd_q && (grp < len)) begin
        issuing <= 1'b1;
        k       <= '0;
      end
      rd_q   <= issuing;
      k_q    <= k;
      last_q <= issuing && k_last;
      if (rd_q && last_q) full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_q) buf_q[k_q] <= mem_rdata;
  end

  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : g_out
      assign bytes_o[gi] = buf_q[gi];
    end
  endgenerate

  assign mem_rd   = issuing;
  assign mem_addr = addr;
  assign full_o   = full;
endmodule

// File: rtl/cfg_lanes.sv
module cfg_lanes
  import cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            load,
  input  logic            step,
  input  mode_e           mode,
  input  logic [3:0]      width,
  input  logic [7:0][7:0] bytes_i,
  output logic [7:0]      data_o,
  output logic            last_o
);
  logic [7:0] sh [8];
  logic [2:0] bidx;
  logic [2:0] sel;
  logic [7:0] nbit;
  logic [7:0] par_byte;
  logic [7:0] next_data;

  assign sel = load ? 3'd0 : bidx + 3'd1;

  genvar k;
  generate
    for (k = 0; k < 8; k++) begin : g_lane
      logic [7:0] src;
      assign src     = load ? bytes_i[k] : sh[k];
      assign nbit[k] = (4'(k) < width) ? src[sel] : 1'b0;
      always_ff @(posedge clk) begin
        if (load) sh[k] <= bytes_i[k];
      end
    end
  endgenerate

  assign par_byte  = load ? bytes_i[0] : sh[0];
  assign next_data = (mode == MODE_PAR) ? par_byte : nbit;
  assign last_o    = (mode == MODE_PAR) || (bidx == 3'd7);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data_o <= '0;
      bidx   <= '0;
    end else if (load) begin
      data_o <= next_data;
      bidx   <= '0;
    end else if (step) begin
      data_o <= next_data;
      bidx   <= bidx + 3'd1;
    end
  end
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_pkg::*;
#(
  parameter int AW       = 12,
  parameter int LW       = 8,
  parameter int EW       = 8,
  parameter int DIV_HALF = 2,
  parameter int TIMEOUT  = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode_sel,
  input  logic [3:0]    lane_cnt,
  input  logic [LW-1:0] stream_len,
  input  logic [EW-1:0] extra_clks,
  input  logic          nstatus_in,
  input  logic          conf_done_in,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          dclk,
  output logic [7:0]    data,
  output logic          busy,
  output logic          cfg_done,
  output logic          cfg_err
);
  localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [HW-1:0] HMAX = HW'(DIV_HALF - 1);

  state_e          st;
  mode_e           mode_q;
  logic [3:0]      width_q;
  logic [LW-1:0]   len_q;
  logic [EW-1:0]   extra_q;
  logic [HW-1:0]   hc;
  logic            dclk_q;
  logic [LW-1:0]   grp;
  logic [EW-1:0]   fc;
  logic [TW-1:0]   tcnt;
  logic            err_q;

  logic            nst_s, done_s;
  logic            fetch_full, fetch_clr, consume;
  logic [7:0][7:0] fetch_bytes;
  logic            lane_load, lane_step, lane_clr, lane_last;
  logic [7:0]      lane_data;
  logic            active, fault_now, half_end, fall, final_beat;

  cfg_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_nst (
    .clk(clk), .rst(rst), .d(nstatus_in), .q(nst_s)
  );
  cfg_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst(rst), .d(conf_done_in), .q(done_s)
  );

  assign active     = (st == ST_PREP) || (st == ST_STREAM) ||
                      (st == ST_FLUSH) || (st == ST_WAITD);
  assign fault_now  = active && !nst_s;
  assign half_end   = (hc == HMAX);
  assign fall       = half_end && dclk_q;
  assign final_beat = lane_last && (grp == LW'(len_q - 1'b1));

  always_comb begin
    lane_load = 1'b0;
    lane_step = 1'b0;
    consume   = 1'b0;
    if (!fault_now) begin
      if (st == ST_PREP && fetch_full) begin
        lane_load = 1'b1;
        consume   = 1'b1;
      end else if (st == ST_STREAM && fall && !final_beat) begin
        if (lane_last) begin
          lane_load = 1'b1;
          consume   = 1'b1;
        end else begin
          lane_step = 1'b1;
        end
      end
    end
  end

  assign lane_clr  = fault_now || (st == ST_STREAM && fall && final_beat) ||
                     !((st == ST_PREP) || (st == ST_STREAM));
  assign fetch_clr = fault_now || (st == ST_IDLE) || (st == ST_HOLD) ||
                     (st == ST_DONE);

  cfg_fetch #(.AW(AW), .LW(LW)) u_fetch (
    .clk(clk), .rst(rst), .clr(fetch_clr), .len(len_q), .width(width_q),
    .consume(consume), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .bytes_o(fetch_bytes), .full_o(fetch_full)
  );

  cfg_lanes u_lanes (
    .clk(clk), .rst(rst), .clr(lane_clr), .load(lane_load), .step(lane_step),
    .mode(mode_q), .width(width_q), .bytes_i(fetch_bytes),
    .data_o(lane_data), .last_o(lane_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mode_q  <= MODE_SER;
      width_q <= 4'd1;
      len_q   <= '0;
      extra_q <= '0;
      hc      <= '0;
      dclk_q  <= 1'b0;
      grp     <= '0;
      fc      <= '0;
      tcnt    <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (fault_now) begin
        st     <= ST_HOLD;
        dclk_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        case (st)
          ST_IDLE, ST_DONE: begin
            dclk_q <= 1'b0;
            if (start) begin
              mode_q  <= decode_mode(mode_sel);
              width_q <= (decode_mode(mode_sel) == MODE_CONC) ?
                         lane_width(lane_cnt) : 4'd1;
              len_q   <= stream_len;
              extra_q <= extra_clks;
              st      <= ST_PREP;
            end
          end
          ST_HOLD: begin
            dclk_q <= 1'b0;
            if (nst_s) st <= ST_PREP;
          end
          ST_PREP: begin
            hc     <= '0;
            dclk_q <= 1'b0;
            grp    <= '0;
            if (fetch_full) st <= ST_STREAM;
          end
          ST_STREAM, ST_FLUSH: begin
            hc <= half_end ? '0 : hc + 1'b1;
            if (half_end) dclk_q <= ~dclk_q;
            if (fall) begin
              if (st == ST_STREAM) begin
                if (final_beat) begin
                  fc   <= '0;
                  tcnt <= '0;
                  st   <= (extra_q == '0) ? ST_WAITD : ST_FLUSH;
                end else if (lane_last) begin
                  grp <= grp + 1'b1;
                end
              end else begin
                fc <= fc + 1'b1;
                if (fc == EW'(extra_q - 1'b1)) begin
                  tcnt <= '0;
                  st   <= ST_WAITD;
                end
              end
            end
          end
          ST_WAITD: begin
            dclk_q <= 1'b0;
            tcnt   <= tcnt + 1'b1;
            if (done_s) begin
              st <= ST_DONE;
            end else if (tcnt == TW'(TIMEOUT - 1)) begin
              st    <= ST_HOLD;
              err_q <= 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign dclk     = dclk_q;
  assign data     = lane_data;
  assign busy     = (st != ST_IDLE) && (st != ST_DONE);
  assign cfg_done = (st == ST_DONE);
  assign cfg_err  = err_q;
endmodule

// File: rtl/cfg_streamer_chk.sv
module cfg_streamer_chk
  import cfg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       dclk,
  input logic [7:0] data,
  input logic       busy,
  input logic       cfg_done,
  input logic       mem_rd,
  input logic       nst_s,
  input logic       done_s,
  input mode_e      mode_q,
  input logic [3:0] width_q,
  input logic       lane_load,
  input logic       fetch_full
);
  // R1
  no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    lane_load |-> fetch_full);

  // R1
  mem_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R2
  serial_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SER) |-> (data[7:1] == 7'd0));

  // R3
  conc_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_CONC) |-> ((data & ~lane_mask(width_q)) == 8'd0));

  // R4
  edge_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data) |-> !dclk);

  // R6
  done_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(done_s));

  // R7
  fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !nst_s |=> (!dclk && data == 8'd0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!dclk && data == 8'd0 && !mem_rd));
endmodule

bind cfg_streamer cfg_streamer_chk u_chk (
  .clk(clk), .rst(rst), .dclk(dclk), .data(data), .busy(busy),
  .cfg_done(cfg_done), .mem_rd(mem_rd), .nst_s(nst_s), .done_s(done_s),
  .mode_q(mode_q), .width_q(width_q), .lane_load(lane_load),
  .fetch_full(fetch_full)
);

// File: tb/tb_cfg_streamer.sv
module tb_cfg_streamer;
  localparam int AW = 12, LW = 8, EW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode_sel = 2'd0;
  logic [3:0]    lane_cnt = 4'd0;
  logic [LW-1:0] stream_len = '0;
  logic [EW-1:0] extra_clks = '0;
  logic          nstatus_in = 1'b1;
  logic          conf_done_in = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'd0;
  logic          dclk;
  logic [7:0]    data;
  logic          busy, cfg_done, cfg_err;

  int n_chk = 0, n_bad = 0;
  int idx = 0, err_cnt = 0, edge_bad = 0;
  logic [7:0] cap [64];
  logic pdclk = 1'b0;
  logic [7:0] pdata = 8'd0;

  always #10 clk = ~clk;

  cfg_streamer #(.AW(AW), .LW(LW), .EW(EW), .DIV_HALF(2), .TIMEOUT(64)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
    .lane_cnt(lane_cnt), .stream_len(stream_len), .extra_clks(extra_clks),
    .nstatus_in(nstatus_in), .conf_done_in(conf_done_in), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dclk(dclk), .data(data),
    .busy(busy), .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  function automatic logic [7:0] memv(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic int width_of(input int lc);
    if (lc <= 1) return 1;
    if (lc == 2) return 2;
    if (lc <= 4) return 4;
    return 8;
  endfunction

  function automatic logic [7:0] exp_beat(input int md, input int w, input int b);
    logic [7:0] r, v;
    r = 8'd0;
    if (md == 0) begin
      r = memv(b);
    end else begin
      for (int k = 0; k < w; k++) begin
        v = memv((b / 8) * w + k);
        r[k] = v[b % 8];
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= memv(int'(mem_addr));
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_err) begin
        err_cnt = err_cnt + 1;
        idx = 0;
      end else if (dclk && !pdclk) begin
        if (idx < 64) cap[idx] = data;
        idx = idx + 1;
      end
      if (dclk && pdclk && data != pdata) edge_bad = edge_bad + 1;
    end
    pdclk = dclk;
    pdata = data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idx(input int target, input int limit);
    for (int t = 0; t < limit && idx < target; t++) @(negedge clk);
  endtask

  task automatic run_cfg(input int md, input int lc, input int len, input int ex,
                         input bit fault, input bit tmo, input string tag);
    int w, beats, total, bad, lim;
    w     = (md == 2) ? width_of(lc) : 1;
    beats = (md == 0) ? len : 8 * len;
    total = beats + ex;
    @(negedge clk);
    mode_sel = 2'(md); lane_cnt = 4'(lc); stream_len = LW'(len);
    extra_clks = EW'(ex); conf_done_in = 1'b0; start = 1'b1;
    idx = 0; err_cnt = 0; edge_bad = 0;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble mode and lane count after start
    mode_sel = 2'(md + 1); lane_cnt = 4'(lc + 3);
    if (fault) begin
      wait_idx(5, 2000);
      nstatus_in = 1'b0;
      repeat (4) @(negedge clk);
      bad = 0;
      for (int t = 0; t < 10; t++) begin
        if (dclk || data != 8'd0) bad++;
        @(negedge clk);
      end
      nstatus_in = 1'b1;
      check(bad == 0, {tag, " R7 quiet while status low"}, bad, 0);
      check(err_cnt == 1, {tag, " R7 error pulse"}, err_cnt, 1);
    end
    if (tmo) begin
      lim = 0;
      while (err_cnt == 0 && lim < 3000) begin @(negedge clk); lim++; end
      check(err_cnt == 1, {tag, " R8 timeout error"}, err_cnt, 1);
    end
    wait_idx(total, 4000);
    repeat (2) @(negedge clk);
    check(cfg_done == 1'b0, {tag, " R6 no done before done line"}, cfg_done, 0);
    conf_done_in = 1'b1;
    lim = 0;
    while (!cfg_done && lim < 20) begin @(negedge clk); lim++; end
    check(cfg_done == 1'b1 && busy == 1'b0, {tag, " R6 done follows line"},
          {cfg_done, busy}, 2);
    repeat (8) @(negedge clk);
    check(idx == total, {tag, " R5 clock count"}, idx, total);
    bad = 0;
    for (int b = 0; b < total && b < 64; b++) begin
      logic [7:0] e;
      e = (b < beats) ? exp_beat(md, w, b) : 8'd0;
      if (cap[b] !== e) begin
        if (bad == 0)
          $display("FAIL %s R1 R2 R3 R9 beat %0d actual=%0h expected=%0h",
                   tag, b, cap[b], e);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
    check(edge_bad == 0, {tag, " R4 data stable while clock high"}, edge_bad, 0);
    conf_done_in = 1'b0;
    mode_sel = 2'(md); lane_cnt = 4'(lc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    check({dclk, data, busy, cfg_done, cfg_err, mem_rd} == 13'd0,
          "R10 reset state", {dclk, data, busy, cfg_done, cfg_err, mem_rd}, 0);
    // R1 parallel, with extra clocks (R5)
    run_cfg(0, 0, 6, 3, 1'b0, 1'b0, "par");
    // R2 serial, no extra clocks; mode code 3 also serial
    run_cfg(1, 0, 3, 0, 1'b0, 1'b0, "ser");
    run_cfg(3, 0, 2, 2, 1'b0, 1'b0, "ser3");
    // R3 sweep of every chain count
    for (int lc = 0; lc <= 8; lc++) run_cfg(2, lc, 2, lc % 3, 1'b0, 1'b0, "conc");
    // R7 fault in the middle of a three-chain stream
    run_cfg(2, 3, 3, 1, 1'b1, 1'b0, "fault");
    // R8 done line held low on the first pass
    run_cfg(1, 0, 2, 1, 1'b0, 1'b1, "tmo");
    run_cfg(2, 6, 1, 0, 1'b0, 1'b1, "tmo8");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule